// File: doc/BRIEF.md
# Conditional DSP Subtract Unit

This block decodes and runs a single 32-bit DSP subtract instruction, issued in one of three flavours: one that always runs, one that runs only while the decision flag (DC) is 1, and one that runs only while DC is 0. Two 2-bit fields pick the source registers X and Y from a small operand file. A 4-bit field picks the destination Z. The difference X − Y lands in Z at the clock edge that accepts the instruction, so every form takes one cycle.

A five-bit status register holds DC, N, Z, V and GT. Only the unconditional flavour changes it. For that flavour, a 3-bit select input decides which condition DC records. The predicated flavours leave the status register untouched, whether or not they run. Any instruction word that does not match is dropped and reported by a one-cycle illegal pulse.

The operand file is filled through a load port and observed through a registered read port.

Top module: `dsub_unit`

## Requirements
- R1: Instruction encoding: bits [31:26] must equal 111110 and bits [25:16] are ignored. Bits [15:8] are the opcode: 0xA1 is unconditional, 0xA2 runs if DC=1, 0xA3 runs if DC=0. Bits [7:6] select X, bits [5:4] select Y and bits [3:0] select Z.
- R2: An unconditional instruction writes X − Y (32-bit two's complement) to register Z. `taken_o` is high in the cycle after issue.
- R3: `flags_o` bit0=DC, bit1=N, bit2=Z, bit3=V, bit4=GT. After an unconditional instruction, N is the result's sign bit and Z is set when the result is zero. V is set on signed overflow of X − Y, and GT is set when X > Y as signed values.
- R4: On an unconditional instruction, DC takes the condition chosen by `dc_sel_i`: 0 = borrow (X < Y unsigned), 1 = N, 2 = Z, 3 = V, 4 = signed X > Y, 5 = signed X ≥ Y. Codes 6 and 7 give DC = 0.
- R5: A predicated form runs (writes Z, `taken_o` high) only when its condition on the DC value held at issue is true. Otherwise the destination is unchanged and `taken_o` stays low.
- R6: Predicated forms never change `flags_o`, whether they run or not.
- R7: A valid word with a wrong prefix or an unknown opcode raises `illegal_o` for one cycle. It writes no register and leaves `flags_o` unchanged.
- R8: Destination codes at or above NUM_REGS (8 by default) write no register. An unconditional instruction with such a code still updates the flags.
- R9: When a load and an instruction write the same register in one cycle, the instruction result is kept. When they target different registers, both writes land.
- R10: Back-to-back instructions are each accepted in one cycle, and a predicated instruction sees the DC left by the instruction issued in the cycle before.
- R11: After reset, `flags_o`, `taken_o` and `illegal_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| dc_sel_i | input | 3 | Condition recorded in DC by the unconditional form |
| ld_en_i | input | 1 | Load-port write enable |
| ld_addr_i | input | 3 | Load-port register index |
| ld_data_i | input | 32 | Load-port data |
| rd_addr_i | input | 3 | Read-port register index |
| rd_data_o | output | 32 | Registered read data |
| flags_o | output | 5 | Status register {GT,V,Z,N,DC} |
| taken_o | output | 1 | Previous-cycle instruction executed |
| illegal_o | output | 1 | Previous-cycle instruction word rejected |

## Verification
Two writes can reach one register in the same edge: a load on the load port and the result of an executing instruction. The bench drives both in one cycle, first to the same register and then to different registers. It then reads each target back through the read port and expects the instruction result in the shared case and both values in the split case. A second overlap is between a flag update and a predicated instruction that follows it at once. This is provoked by issuing the two with no idle cycle and judged by whether the second one runs.

// File: rtl/dsub_pkg.sv
package dsub_pkg;

  localparam logic [5:0] PREFIX     = 6'b111110;
  localparam logic [7:0] OPC_ALWAYS = 8'hA1;
  localparam logic [7:0] OPC_IF_SET = 8'hA2;
  localparam logic [7:0] OPC_IF_CLR = 8'hA3;

  localparam logic [2:0] DCS_BORROW = 3'd0;
  localparam logic [2:0] DCS_NEG    = 3'd1;
  localparam logic [2:0] DCS_ZERO   = 3'd2;
  localparam logic [2:0] DCS_OVF    = 3'd3;
  localparam logic [2:0] DCS_GT     = 3'd4;
  localparam logic [2:0] DCS_GE     = 3'd5;

  typedef enum logic [1:0] {
    FORM_NONE   = 2'd0,
    FORM_ALWAYS = 2'd1,
    FORM_IF_SET = 2'd2,
    FORM_IF_CLR = 2'd3
  } form_e;

  // bit0 = dc ... bit4 = gt
  typedef struct packed {
    logic gt;
    logic v;
    logic z;
    logic n;
    logic dc;
  } flags_t;

endpackage

// File: rtl/dsub_decode.sv
module dsub_decode
  import dsub_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output form_e       form_o,
  output logic        illegal_o,
  output logic [1:0]  xsel_o,
  output logic [1:0]  ysel_o,
  output logic [3:0]  zsel_o
);

  logic unused_upper;
  assign unused_upper = ^instr_i[25:16];

  assign xsel_o = instr_i[7:6];
  assign ysel_o = instr_i[5:4];
  assign zsel_o = instr_i[3:0];

  always_comb begin
    form_o    = FORM_NONE;
    illegal_o = 1'b0;
    if (valid_i) begin
      if (instr_i[31:26] != PREFIX) begin
        illegal_o = 1'b1;
      end else begin
        unique case (instr_i[15:8])
          OPC_ALWAYS: form_o = FORM_ALWAYS;
          OPC_IF_SET: form_o = FORM_IF_SET;
          OPC_IF_CLR: form_o = FORM_IF_CLR;
          default:    illegal_o = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/dsub_alu.sv
module dsub_alu
  import dsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        dc_sel_i,
  output logic [DATA_W-1:0] diff_o,
  output flags_t            flags_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;
  logic borrow, neg, zero, ovf, sgt, sge;

  assign wide   = {1'b0, a_i} - {1'b0, b_i};
  assign diff_o = wide[MSB:0];
  assign borrow = wide[DATA_W];
  assign neg    = wide[MSB];
  assign zero   = (wide[MSB:0] == '0);
  assign ovf    = (a_i[MSB] != b_i[MSB]) && (wide[MSB] != a_i[MSB]);
  assign sge    = (neg == ovf);
  assign sgt    = sge && !zero;

  always_comb begin
    flags_o.n  = neg;
    flags_o.z  = zero;
    flags_o.v  = ovf;
    flags_o.gt = sgt;
    case (dc_sel_i)
      DCS_BORROW: flags_o.dc = borrow;
      DCS_NEG:    flags_o.dc = neg;
      DCS_ZERO:   flags_o.dc = zero;
      DCS_OVF:    flags_o.dc = ovf;
      DCS_GT:     flags_o.dc = sgt;
      DCS_GE:     flags_o.dc = sge;
      default:    flags_o.dc = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsub_regfile.sv
module dsub_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_we_i,
  input  logic [AW-1:0]     ex_addr_i,
  input  logic [DATA_W-1:0] ex_data_i,
  input  logic              ld_we_i,
  input  logic [AW-1:0]     ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [1:0]        xsel_i,
  input  logic [1:0]        ysel_i,
  output logic [DATA_W-1:0] x_data_o,
  output logic [DATA_W-1:0] y_data_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [NUM_REGS-1:0] ex_hit, ld_hit;
  logic [AW-1:0] xi, yi;

  assign xi = AW'(xsel_i);
  assign yi = AW'(ysel_i);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign ex_hit[i] = ex_we_i && (ex_addr_i == AW'(i));
    assign ld_hit[i] = ld_we_i && (ld_addr_i == AW'(i));
  end

  // execute result has priority over the load port on a shared entry
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ex_hit[i])      mem[i] <= ex_data_i;
      else if (ld_hit[i]) mem[i] <= ld_data_i;
    end
  end

  assign x_data_o = mem[xi];
  assign y_data_o = mem[yi];

  always_ff @(posedge clk) begin
    rd_data_o <= mem[rd_addr_i];
  end

  assert_exec_beats_load_R9: assert property (@(posedge clk) disable iff (rst)
    (ex_we_i && ld_we_i && ex_addr_i == ld_addr_i)
      |=> (mem[$past(ex_addr_i)] == $past(ex_data_i)));

  assert_load_lands_R9: assert property (@(posedge clk) disable iff (rst)
    (ld_we_i && !(ex_we_i && ex_addr_i == ld_addr_i))
      |=> (mem[$past(ld_addr_i)] == $past(ld_data_i)));

endmodule

// File: rtl/dsub_unit.sv
module dsub_unit
  import dsub_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid_i,
  input  logic [31:0]       instr_i,
  input  logic [2:0]        dc_sel_i,
  input  logic              ld_en_i,
  input  logic [AW-1:0]     ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [4:0]        flags_o,
  output logic              taken_o,
  output logic              illegal_o
);

  form_e             form;
  logic              dec_illegal;
  logic [1:0]        xsel, ysel;
  logic [3:0]        zsel;
  logic [DATA_W-1:0] x_data, y_data, diff;
  flags_t            alu_flags, flags_q;
  logic              cond_ok, dst_ok, ex_we;

  dsub_decode u_decode (
    .valid_i   (instr_valid_i),
    .instr_i   (instr_i),
    .form_o    (form),
    .illegal_o (dec_illegal),
    .xsel_o    (xsel),
    .ysel_o    (ysel),
    .zsel_o    (zsel)
  );

  dsub_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ex_we_i   (ex_we),
    .ex_addr_i (zsel[AW-1:0]),
    .ex_data_i (diff),
    .ld_we_i   (ld_en_i),
    .ld_addr_i (ld_addr_i),
    .ld_data_i (ld_data_i),
    .xsel_i    (xsel),
    .ysel_i    (ysel),
    .x_data_o  (x_data),
    .y_data_o  (y_data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  dsub_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i      (x_data),
    .b_i      (y_data),
    .dc_sel_i (dc_sel_i),
    .diff_o   (diff),
    .flags_o  (alu_flags)
  );

  always_comb begin
    case (form)
      FORM_ALWAYS: cond_ok = 1'b1;
      FORM_IF_SET: cond_ok = flags_q.dc;
      FORM_IF_CLR: cond_ok = !flags_q.dc;
      default:     cond_ok = 1'b0;
    endcase
  end

  assign dst_ok = (int'(zsel) < NUM_REGS);
  assign ex_we  = cond_ok && dst_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      taken_o   <= cond_ok;
      illegal_o <= dec_illegal;
      if (form == FORM_ALWAYS) flags_q <= alu_flags;
    end
  end

  assign flags_o = flags_q;

  assert_always_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (form == FORM_ALWAYS) |=> taken_o);

  assert_false_cond_idle_R5: assert property (@(posedge clk) disable iff (rst)
    ((form == FORM_IF_SET && !flags_q.dc) || (form == FORM_IF_CLR && flags_q.dc))
      |=> !taken_o);

  assert_pred_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (form == FORM_IF_SET || form == FORM_IF_CLR) |=> $stable(flags_o));

  assert_illegal_inert_R7: assert property (@(posedge clk) disable iff (rst)
    dec_illegal |=> (illegal_o && !taken_o && $stable(flags_o)));

  assert_single_outcome_R7: assert property (@(posedge clk) disable iff (rst)
    !(illegal_o && taken_o));

endmodule

// File: tb/dsub_unit_tb.sv
module dsub_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [2:0]  dc_sel_i = '0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_addr_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [4:0]  flags_o;
  logic        taken_o, illegal_o;

  int n_checks = 0;
  int n_fails  = 0;

  logic [31:0] mreg [NREG];
  logic [4:0]  mflags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsub_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .dc_sel_i(dc_sel_i), .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .flags_o(flags_o), .taken_o(taken_o), .illegal_o(illegal_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flags {gt,v,z,n,dc} from the requirement text
  function automatic logic [4:0] model_flags(logic [31:0] a, logic [31:0] b, logic [2:0] sel);
    longint t;
    logic [31:0] d;
    logic n, z, v, gt, ge, dc;
    t  = longint'($signed(a)) - longint'($signed(b));
    d  = a - b;
    n  = d[31];
    z  = (d == 32'd0);
    v  = (t > 64'sd2147483647) || (t < -64'sd2147483648);
    gt = $signed(a) > $signed(b);
    ge = $signed(a) >= $signed(b);
    case (sel)
      3'd0: dc = (a < b);
      3'd1: dc = n;
      3'd2: dc = z;
      3'd3: dc = v;
      3'd4: dc = gt;
      3'd5: dc = ge;
      default: dc = 1'b0;
    endcase
    return {gt, v, z, n, dc};
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic issue(string tag, logic [7:0] opc, bit good_prefix,
                       int x, int y, int z, logic [2:0] sel);
    bit legal, cond;
    legal = good_prefix && (opc == 8'hA1 || opc == 8'hA2 || opc == 8'hA3);
    cond  = (opc == 8'hA1) || (opc == 8'hA2 && mflags[0]) || (opc == 8'hA3 && !mflags[0]);
    instr_valid_i = 1'b1;
    instr_i  = {(good_prefix ? 6'b111110 : 6'b111100), 10'h2A5, opc,
                2'(x), 2'(y), 4'(z)};
    dc_sel_i = sel;
    if (legal && cond && z < NREG) mreg[z] = mreg[x] - mreg[y];
    if (legal && opc == 8'hA1) mflags = model_flags(mreg[x], mreg[y], sel);
    @(negedge clk);
    instr_valid_i = 1'b0;
    check({tag, " taken"},   32'(taken_o),   32'(legal && cond));
    check({tag, " illegal"}, 32'(illegal_o), 32'(!legal));
    check({tag, " flags"},   32'(flags_o),   32'(mflags));
  endtask

  task automatic load(int a, logic [31:0] d);
    ld_en_i = 1'b1; ld_addr_i = 3'(a); ld_data_i = d; mreg[a] = d;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic read_check(string tag, int a);
    rd_addr_i = 3'(a);
    @(negedge clk);
    check({tag, " reg"}, rd_data_o, mreg[a]);
  endtask

  task automatic t_reset();
    check("R11 flags", 32'(flags_o), 32'd0);
    check("R11 taken", 32'(taken_o), 32'd0);
    check("R11 illegal", 32'(illegal_o), 32'd0);
  endtask

  task automatic t_basic();
    issue("R2 R3 R4 pos", 8'hA1, 1, 0, 1, 4, 3'd0);   // 100-30
    check("R3 pos flags", 32'(flags_o), 32'h10);
    read_check("R2 r4", 4);
    issue("R2 R3 R4 neg", 8'hA1, 1, 1, 0, 5, 3'd0);   // 30-100, borrow
    check("R3 neg flags", 32'(flags_o), 32'h03);
    read_check("R2 r5", 5);
  endtask

  task automatic t_predicated();
    issue("R5 R6 set-taken", 8'hA2, 1, 0, 0, 6, 3'd5);
    read_check("R5 r6", 6);
    issue("R5 R6 clr-skip", 8'hA3, 1, 0, 1, 7, 3'd5);
    read_check("R5 r7 kept", 7);
  endtask

  task automatic t_dcsel();
    issue("R4 R3 ovf", 8'hA1, 1, 2, 3, 6, 3'd3);       // 0x80000000-1
    check("R3 ovf flags", 32'(flags_o), 32'h09);
    issue("R4 zero", 8'hA1, 1, 1, 1, 7, 3'd2);
    check("R4 zero flags", 32'(flags_o), 32'h05);
    issue("R4 ge", 8'hA1, 1, 0, 1, 6, 3'd5);
    issue("R4 gt-equal", 8'hA1, 1, 3, 3, 6, 3'd4);
    issue("R4 neg", 8'hA1, 1, 1, 0, 6, 3'd1);
    issue("R4 sel6", 8'hA1, 1, 1, 0, 6, 3'd6);
    issue("R4 sel7", 8'hA1, 1, 2, 3, 6, 3'd7);
    read_check("R4 r6", 6);
  endtask

  task automatic t_illegal();
    issue("R7 prefix", 8'hA1, 0, 0, 1, 4, 3'd0);
    read_check("R7 r4 kept", 4);
    issue("R7 opcode", 8'hA4, 1, 0, 1, 5, 3'd0);
    read_check("R7 r5 kept", 5);
  endtask

  task automatic t_dest();
    issue("R8 dest9", 8'hA1, 1, 1, 0, 9, 3'd0);
    check("R8 flags", 32'(flags_o), 32'h03);
    read_check("R8 r1 kept", 1);
    issue("R8 dest15 pred", 8'hA2, 1, 0, 1, 15, 3'd0);
    read_check("R8 r7 kept", 7);
  endtask

  task automatic t_conflict();
    ld_en_i = 1'b1; ld_addr_i = 3'd4; ld_data_i = 32'hDEAD_BEEF;
    mreg[4] = 32'hDEAD_BEEF;
    issue("R9 same", 8'hA1, 1, 0, 3, 4, 3'd0);
    ld_en_i = 1'b0;
    read_check("R9 same r4", 4);
    ld_en_i = 1'b1; ld_addr_i = 3'd5; ld_data_i = 32'hCAFE_0005;
    mreg[5] = 32'hCAFE_0005;
    issue("R9 split", 8'hA1, 1, 1, 3, 6, 3'd0);
    ld_en_i = 1'b0;
    read_check("R9 split r5", 5);
    read_check("R9 split r6", 6);
  endtask

  task automatic t_back_to_back();
    issue("R10 set dc1", 8'hA1, 1, 1, 0, 4, 3'd0);  // borrow -> DC=1
    issue("R10 clr dc0", 8'hA1, 1, 0, 1, 5, 3'd0);  // no borrow -> DC=0
    issue("R10 pred-clr", 8'hA3, 1, 0, 3, 6, 3'd0); // must run
    issue("R10 pred-set", 8'hA2, 1, 0, 3, 7, 3'd0); // must not run
    read_check("R10 r6", 6);
    read_check("R10 r7", 7);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    load(0, 32'd100);
    load(1, 32'd30);
    load(2, 32'h8000_0000);
    load(3, 32'd1);
    load(4, 32'h11);
    load(5, 32'h22);
    load(6, 32'h33);
    load(7, 32'h1234);
    t_basic();
    t_predicated();
    t_dcsel();
    t_illegal();
    t_dest();
    t_conflict();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule